// File: doc/BRIEF.md
# Dual-Direction Latched and Edge-Captured Bus Transceiver

This block moves an 18-bit word between two ports, A and B, through two independent paths: one from A to B and one from B to A. Each path has one storage stage that works in three ways. It can pass its input straight through (open), keep a stored word (closed), or take a new word when its path strobe falls. Each direction is steered by three inputs: an open control, a path strobe and a drive control. The A-to-B drive control is active high. The B-to-A drive control is active low.

The block is synchronous to one system clock. The path strobes and open controls are sampled as levels on each rising system-clock edge. A strobe fall is a strobe that was high at one edge and low at the next. Each port has a data output and a separate drive-enable bit. Any three-state resolution is left to the logic outside the block.

Each path runs a four-state machine that remembers the open control and strobe level seen at the previous edge:
- OPEN_HI: open high, strobe high.
- OPEN_LO: open high, strobe low.
- ARMED: open low, strobe high.
- CLOSED: open low, strobe low.

On every edge the machine moves to the state named by the sampled pair, from any state. The path captures its input when it sits in ARMED or OPEN_HI and samples open low with the strobe low. Reset puts the machine in CLOSED.

Top module: `bus_xcvr`

## Requirements
- R1: A synchronous reset clears both stored words to zero. After reset, a path whose open control is low drives zero.
- R2: While `ab_open` is high, `b_data` equals `a_in` in the same cycle.
- R3: With `ab_open` low, a fall of `ab_strobe` (high at one edge, low at the next) loads the `a_in` seen at the second edge. `b_data` shows that word from the following cycle.
- R4: With `ab_open` low and `ab_strobe` steady high or steady low, `b_data` keeps its stored word.
- R5: When `ab_open` drops while `ab_strobe` is high, the path keeps the last word it passed while open, until the strobe falls.
- R6: `b_drive_en` equals `ab_drive_on` (active high), whatever the open and strobe inputs are.
- R7: `a_drive_en` is high exactly when `ba_drive_off_n` is low (active low), whatever the open and strobe inputs are.
- R8: The B-to-A path follows R2 to R5 and R10 from `b_in` to `a_data`, using `ba_open` and `ba_strobe`.
- R9: Activity on one direction never changes the stored word of the other direction.
- R10: When the open control drops at the same edge where the strobe is first seen low after being high, the path loads the input present at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| a_in | input | 18 | Word arriving on port A |
| b_in | input | 18 | Word arriving on port B |
| ab_open | input | 1 | A-to-B pass-through control |
| ab_strobe | input | 1 | A-to-B capture strobe, falling |
| ab_drive_on | input | 1 | B-port drive control, active high |
| ba_open | input | 1 | B-to-A pass-through control |
| ba_strobe | input | 1 | B-to-A capture strobe, falling |
| ba_drive_off_n | input | 1 | A-port drive control, active low |
| b_data | output | 18 | Word presented on port B |
| b_drive_en | output | 1 | Port B should be driven |
| a_data | output | 18 | Word presented on port A |
| a_drive_en | output | 1 | Port A should be driven |

## Verification
The assertions take for granted that every control and data input is stable around the rising system-clock edge. They also take for granted that each strobe level lasts at least one full system cycle, so every fall is seen as a high sample followed by a low sample. The stimulus changes all inputs only on falling clock edges and holds each strobe level for whole cycles. Because of this, every fall, every steady hold and every close-while-strobe-high case lands on a known edge.

// File: rtl/bus_xcvr_pkg.sv
package bus_xcvr_pkg;
    // Previous-edge memory of one path: open control and strobe level
    typedef enum logic [1:0] {
        PS_CLOSED  = 2'b00,
        PS_ARMED   = 2'b01,
        PS_OPEN_LO = 2'b10,
        PS_OPEN_HI = 2'b11
    } path_state_t;
endpackage

// File: rtl/xcvr_store.sv
module xcvr_store
    import bus_xcvr_pkg::*;
#(
    parameter int  WIDTH   = 18,
    parameter bit  HAS_RST = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    input  logic             open_i,
    input  logic             strobe_i,
    output logic [WIDTH-1:0] dout
);
    path_state_t      state_q;
    path_state_t      state_d;
    logic             armed;
    logic             load;
    logic [WIDTH-1:0] word_q;

    // Next state is named by the sampled pair, from any state
    always_comb begin
        unique case ({open_i, strobe_i})
            2'b00:   state_d = PS_CLOSED;
            2'b01:   state_d = PS_ARMED;
            2'b10:   state_d = PS_OPEN_LO;
            default: state_d = PS_OPEN_HI;
        endcase
    end

    // Output decode: a fall is pending only from strobe-high states
    always_comb begin
        unique case (state_q)
            PS_ARMED, PS_OPEN_HI: armed = 1'b1;
            default:              armed = 1'b0;
        endcase
        load = open_i | (armed & ~strobe_i);
        dout = open_i ? din : word_q;
    end

    generate
        if (HAS_RST) begin : g_rst
            always_ff @(posedge clk) begin
                if (rst) begin
                    state_q <= PS_CLOSED;
                    word_q  <= '0;
                end else begin
                    state_q <= state_d;
                    if (load) word_q <= din;
                end
            end
        end else begin : g_norst
            always_ff @(posedge clk) begin
                state_q <= state_d;
                if (load) word_q <= din;
            end
        end
    endgenerate
endmodule

// File: rtl/xcvr_drive.sv
module xcvr_drive #(
    parameter bit ACTIVE_LOW = 1'b0
) (
    input  logic ctrl,
    output logic drive_en
);
    generate
        if (ACTIVE_LOW) begin : g_low
            assign drive_en = ~ctrl;
        end else begin : g_high
            assign drive_en = ctrl;
        end
    endgenerate
endmodule

// File: rtl/bus_xcvr.sv
module bus_xcvr #(
    parameter int DATA_W  = 18,
    parameter bit HAS_RST = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] a_in,
    input  logic [DATA_W-1:0] b_in,
    input  logic              ab_open,
    input  logic              ab_strobe,
    input  logic              ab_drive_on,
    input  logic              ba_open,
    input  logic              ba_strobe,
    input  logic              ba_drive_off_n,
    output logic [DATA_W-1:0] b_data,
    output logic              b_drive_en,
    output logic [DATA_W-1:0] a_data,
    output logic              a_drive_en
);
    xcvr_store #(.WIDTH(DATA_W), .HAS_RST(HAS_RST)) u_store_ab (
        .clk(clk), .rst(rst), .din(a_in),
        .open_i(ab_open), .strobe_i(ab_strobe), .dout(b_data)
    );

    xcvr_store #(.WIDTH(DATA_W), .HAS_RST(HAS_RST)) u_store_ba (
        .clk(clk), .rst(rst), .din(b_in),
        .open_i(ba_open), .strobe_i(ba_strobe), .dout(a_data)
    );

    xcvr_drive #(.ACTIVE_LOW(1'b0)) u_drive_b (
        .ctrl(ab_drive_on), .drive_en(b_drive_en)
    );

    xcvr_drive #(.ACTIVE_LOW(1'b1)) u_drive_a (
        .ctrl(ba_drive_off_n), .drive_en(a_drive_en)
    );
endmodule

// File: rtl/bus_xcvr_checker.sv
module bus_xcvr_checker #(
    parameter int DATA_W = 18
) (
    input logic              clk,
    input logic              rst,
    input logic [DATA_W-1:0] a_in,
    input logic [DATA_W-1:0] b_in,
    input logic              ab_open,
    input logic              ab_strobe,
    input logic              ab_drive_on,
    input logic              ba_open,
    input logic              ba_strobe,
    input logic              ba_drive_off_n,
    input logic [DATA_W-1:0] b_data,
    input logic              b_drive_en,
    input logic [DATA_W-1:0] a_data,
    input logic              a_drive_en
);
    AST_RESET_CLEARS: assert property (@(posedge clk)
        ($past(rst) && !rst && !ab_open) |-> (b_data == '0)); // R1

    AST_AB_PASS: assert property (@(posedge clk) disable iff (rst)
        ab_open |-> (b_data == a_in)); // R2

    AST_AB_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        (!ab_open && !ab_strobe && $past(ab_strobe) && !$past(rst))
        |=> (ab_open || b_data == $past(a_in))); // R3

    AST_AB_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!ab_open && !(!ab_strobe && $past(ab_strobe)))
        |=> (ab_open || b_data == $past(b_data))); // R4

    AST_B_DRIVE: assert property (@(posedge clk) disable iff (rst)
        b_drive_en == ab_drive_on); // R6

    AST_A_DRIVE: assert property (@(posedge clk) disable iff (rst)
        a_drive_en != ba_drive_off_n); // R7

    AST_BA_PASS: assert property (@(posedge clk) disable iff (rst)
        ba_open |-> (a_data == b_in)); // R8

    AST_BA_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        (!ba_open && !ba_strobe && $past(ba_strobe) && !$past(rst))
        |=> (ba_open || a_data == $past(b_in))); // R8

    AST_BA_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!ba_open && !(!ba_strobe && $past(ba_strobe)))
        |=> (ba_open || a_data == $past(a_data))); // R9
endmodule

bind bus_xcvr bus_xcvr_checker #(.DATA_W(DATA_W)) u_checker (.*);

// File: tb/test_bus_xcvr.sv
module test_bus_xcvr;
    localparam int W = 18;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] a_in = '0, b_in = '0;
    logic         ab_open = 0, ab_strobe = 0, ab_drive_on = 0;
    logic         ba_open = 0, ba_strobe = 0, ba_drive_off_n = 1;
    logic [W-1:0] b_data, a_data;
    logic         b_drive_en, a_drive_en;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // reference state
    logic [W-1:0] ref_ab = '0, ref_ba = '0;
    logic         prv_sab = 0, prv_sba = 0, prv_oab = 0, prv_oba = 0;
    string        tag_ab = "R1", tag_ba = "R1";

    always #2 clk = ~clk;

    bus_xcvr i_bus_xcvr (
        .clk(clk), .rst(rst), .a_in(a_in), .b_in(b_in),
        .ab_open(ab_open), .ab_strobe(ab_strobe), .ab_drive_on(ab_drive_on),
        .ba_open(ba_open), .ba_strobe(ba_strobe), .ba_drive_off_n(ba_drive_off_n),
        .b_data(b_data), .b_drive_en(b_drive_en),
        .a_data(a_data), .a_drive_en(a_drive_en)
    );

    task automatic check(input string req, input logic [W-1:0] got, input logic [W-1:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // update the reference after a rising edge
    task automatic ref_update();
        logic fall;
        if (rst) begin
            ref_ab = '0; ref_ba = '0; prv_sab = 0; prv_sba = 0;
            prv_oab = 0; prv_oba = 0; tag_ab = "R1"; tag_ba = "R1";
        end else begin
            fall = prv_sab && !ab_strobe;
            if (ab_open) begin ref_ab = a_in; tag_ab = "R5"; end
            else if (fall) begin ref_ab = a_in; tag_ab = prv_oab ? "R10" : "R3"; end
            else if (tag_ab != "R1" && tag_ab != "R5") tag_ab = "R4";
            fall = prv_sba && !ba_strobe;
            if (ba_open) ref_ba = b_in;
            else if (fall) ref_ba = b_in;
            tag_ba = "R8 R9";
            prv_sab = ab_strobe; prv_oab = ab_open;
            prv_sba = ba_strobe; prv_oba = ba_open;
        end
    endtask

    task automatic step(input logic ao, input logic as_, input logic ad,
                        input logic bo, input logic bs, input logic bdn,
                        input logic [W-1:0] a, input logic [W-1:0] b);
        @(negedge clk);
        ab_open = ao; ab_strobe = as_; ab_drive_on = ad;
        ba_open = bo; ba_strobe = bs; ba_drive_off_n = bdn;
        a_in = a; b_in = b;
        #1;
        if (!rst) begin
            check(ao ? "R2" : tag_ab, b_data, ao ? a : ref_ab);
            check(bo ? "R8" : tag_ba, a_data, bo ? b : ref_ba);
            check("R6", {{(W-1){1'b0}}, b_drive_en}, {{(W-1){1'b0}}, ad});
            check("R7", {{(W-1){1'b0}}, a_drive_en}, {{(W-1){1'b0}}, ~bdn});
        end
        @(posedge clk);
        ref_update();
    endtask

    initial begin
        #400000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        rst = 1;
        step(0,1,0, 0,1,1, 18'h3FFFF, 18'h2AAAA);
        step(0,1,0, 0,1,1, 18'h3FFFF, 18'h2AAAA);
        rst = 0;
        // R1: outputs zero while closed, strobe held high (no fall yet)
        step(0,1,1, 0,1,0, 18'h11111, 18'h22222);
        // R3: strobe falls on AB, capture 0x12345
        step(0,0,1, 0,1,0, 18'h12345, 18'h22222);
        // R4: hold low, inputs change
        step(0,0,1, 0,1,0, 18'h00F0F, 18'h22222);
        step(0,0,1, 0,1,0, 18'h3C3C3, 18'h22222);
        // R4: strobe rises, hold high
        step(0,1,1, 0,1,0, 18'h15555, 18'h22222);
        step(0,1,1, 0,1,0, 18'h0AAAA, 18'h22222);
        // R8: BA strobe falls captures b_in; R9: AB unchanged
        step(0,1,1, 0,0,0, 18'h0AAAA, 18'h0BEEF);
        step(0,1,0, 0,0,1, 18'h01234, 18'h30000);
        // R2: AB transparent with varied data
        step(1,1,0, 0,0,1, 18'h01111, 18'h30000);
        step(1,1,1, 0,0,1, 18'h2F00F, 18'h30001);
        // R5: open drops while strobe high, then data changes
        step(0,1,1, 0,0,1, 18'h00001, 18'h30002);
        step(0,1,1, 0,0,1, 18'h00002, 18'h30003);
        // R3: subsequent fall captures new word
        step(0,0,1, 0,0,1, 18'h0CAFE, 18'h30004);
        step(0,0,1, 0,0,1, 18'h00000, 18'h30005);
        // R10: open and strobe fall at the same edge
        step(1,1,1, 0,0,1, 18'h2D00D, 18'h30006);
        step(0,0,1, 0,0,1, 18'h1ABCD, 18'h30007);
        step(0,0,1, 0,0,1, 18'h00000, 18'h30008);
        // R5 low-strobe: open drops with strobe low keeps open word
        step(1,0,1, 0,0,1, 18'h05A5A, 18'h30009);
        step(0,0,1, 0,0,1, 18'h3FFFF, 18'h3000A);
        step(0,0,1, 0,0,1, 18'h00000, 18'h3000B);
        // R8: BA transparent, then close with strobe high, then fall
        step(0,0,1, 1,1,0, 18'h00000, 18'h1F1F1);
        step(0,0,1, 0,1,0, 18'h00000, 18'h0E0E0);
        step(0,0,1, 0,0,0, 18'h00000, 18'h07070);
        step(0,0,1, 0,0,0, 18'h00000, 18'h00000);
        // R10 on BA
        step(0,0,1, 1,1,1, 18'h00000, 18'h24242);
        step(0,0,1, 0,0,1, 18'h00000, 18'h13131);
        step(0,0,1, 0,0,1, 18'h00000, 18'h00000);
        // R6 R7: drive toggles with every control combination
        for (int k = 0; k < 16; k++)
            step(k[0], k[1], k[2], k[3], ~k[1], ~k[2], 18'(k * 4099), 18'(k * 2053));
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule